// File: doc/BRIEF.md
# Run-Length Sequence Detector

This block watches a serial bit stream, one bit per clock, and raises a detect flag when a run of at least two ones is followed by a run of at least three zeros. The flag rises in the cycle that carries the third zero of that zero run. It stays high while zeros keep arriving and falls in the cycle that brings the next one. The output is Mealy-style: it combines the registered run history with the current input bit, so it reacts in the same cycle as the bit that decides it.

Two saturating run counters track the ones run and the zeros run. A one-bit qualifier records whether the ones run that came before the current zero run was long enough. A one always starts or extends a ones run. This includes a one that ends an asserted period and a one that breaks a zero run early, so in both cases counting restarts at one.

Top module: `run_length_detector`

## Requirements
- R1: While the synchronous reset `rst` is high, `det` is 0. After reset the history is as if only zeros had been seen with no earlier ones, so zeros alone never raise `det`.
- R2: `det` is 1 in the same cycle that `din`=0 is the third zero of a zero run, provided that run directly follows a run of two or more ones.
- R3: A ones run of length one never qualifies, however long the zero run that follows it.
- R4: A ones run longer than two behaves exactly like a run of two.
- R5: Once `det` is 1, it stays 1 in every following cycle where `din` is 0.
- R6: In any cycle where `din` is 1, `det` is 0 in that same cycle.
- R7: The one that ends an asserted period counts as the first one of a new ones run. A second one after it re-arms detection.
- R8: A zero run of only one or two zeros never raises `det`. A one arriving during it restarts ones counting at one, so the earlier ones run no longer counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `din` is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| det | output | 1 | Detect flag (Mealy, depends on current `din`) |

## Verification
The bench builds the block with its default limits: a ones threshold of two and a zeros threshold of three. These defaults make the saturation of both counters reachable with short runs, so the rule that longer runs behave the same gets exercised all the time. Random runs of one to six bits cross both thresholds from below and above. Directed strings cover lone ones, zero runs that are broken early, and re-arming straight after an asserted period.

// File: rtl/rld_pkg.sv
`timescale 1ns/1ps
package rld_pkg;

    // Registered state of the qualifier: whether the ones run before the
    // current zero run reached the minimum length.
    typedef struct packed {
        logic qualified;
    } arm_state_t;

endpackage

// File: rtl/rld_run_counter.sv
`timescale 1ns/1ps
// Saturating run-length counter: clears on clr, counts up on inc, and holds
// at LIMIT.
module rld_run_counter #(
    parameter int unsigned LIMIT      = 2,
    parameter bit          START_FULL = 1'b0,
    localparam int unsigned W         = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         full
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != W'(LIMIT))) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= START_FULL ? W'(LIMIT) : '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign full  = (st_q.cnt == W'(LIMIT));

endmodule

// File: rtl/rld_arm.sv
`timescale 1ns/1ps
// Qualifier and Mealy output stage.
module rld_arm
    import rld_pkg::*;
#(
    parameter int unsigned ZEROS_MIN = 3,
    parameter int unsigned OW        = 2,
    parameter int unsigned ZW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [OW-1:0] ones_cnt,
    input  logic          ones_full,
    input  logic [ZW-1:0] zeros_cnt,
    output logic          det
);

    arm_state_t st_d, st_q;
    logic       in_ones_run;
    logic       qual_now;
    logic       zeros_enough;

    // A non-zero ones count means the previous sample was a one. The current
    // zero (if any) then opens a new zero run, so the ones count decides.
    assign in_ones_run  = (ones_cnt != '0);
    assign qual_now     = in_ones_run ? ones_full : st_q.qualified;
    assign zeros_enough = (int'(zeros_cnt) + 1) >= int'(ZEROS_MIN);

    always_comb begin
        st_d = st_q;
        if (din) begin
            st_d.qualified = 1'b0;
        end else begin
            st_d.qualified = qual_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.qualified <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det = !rst && !din && qual_now && zeros_enough;

endmodule

// File: rtl/run_length_detector.sv
`timescale 1ns/1ps
module run_length_detector #(
    parameter int unsigned ONES_MIN  = 2,
    parameter int unsigned ZEROS_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic det
);

    localparam int unsigned OW = $clog2(ONES_MIN + 1);
    localparam int unsigned ZW = $clog2(ZEROS_MIN + 1);

    logic [OW-1:0] ones_cnt;
    logic [ZW-1:0] zeros_cnt;
    logic          ones_full;
    logic          zeros_full;

    // Ones run: cleared by a zero, starts from zero after reset.
    rld_run_counter #(
        .LIMIT      (ONES_MIN),
        .START_FULL (1'b0)
    ) u_ones (
        .clk   (clk),
        .rst   (rst),
        .clr   (!din),
        .inc   (din),
        .count (ones_cnt),
        .full  (ones_full)
    );

    // Zeros run: reset looks like a long history of zeros.
    rld_run_counter #(
        .LIMIT      (ZEROS_MIN),
        .START_FULL (1'b1)
    ) u_zeros (
        .clk   (clk),
        .rst   (rst),
        .clr   (din),
        .inc   (!din),
        .count (zeros_cnt),
        .full  (zeros_full)
    );

    rld_arm #(
        .ZEROS_MIN (ZEROS_MIN),
        .OW        (OW),
        .ZW        (ZW)
    ) u_arm (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .ones_cnt  (ones_cnt),
        .ones_full (ones_full),
        .zeros_cnt (zeros_cnt),
        .det       (det)
    );

    logic unused_full;
    assign unused_full = zeros_full;

endmodule

// File: rtl/rld_checker.sv
`timescale 1ns/1ps
module rld_checker (
    input logic clk,
    input logic rst,
    input logic din,
    input logic det
);

    // R1: reset holds the flag low
    p_reset_low_r1: assert property (@(posedge clk) rst |-> !det);

    // R6: a one in the current cycle forces the flag low
    p_one_clears_r6: assert property (@(posedge clk) disable iff (rst) din |-> !det);

    // R5: an asserted flag is held while zeros continue
    p_hold_r5: assert property (@(posedge clk) disable iff (rst) det |=> (din || det));

    // R2: a rising flag follows three zeros
    p_three_zeros_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(det) |-> (!din && !$past(din) && !$past(din, 2)));

    // R3: a rising flag follows at least two ones before those zeros
    p_two_ones_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(det) |-> ($past(din, 3) && $past(din, 4)));

endmodule

bind run_length_detector rld_checker u_chk (
    .clk (clk),
    .rst (rst),
    .din (din),
    .det (det)
);

// File: tb/run_length_detector_tb.sv
`timescale 1ns/1ps
module run_length_detector_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic det;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference history
    int cur_ones  = 0;
    int cur_zeros = 0;
    int last_ones = 0;

    always #10 clk = ~clk;

    run_length_detector u_dut (
        .clk (clk),
        .rst (rst),
        .din (din),
        .det (det)
    );

    function automatic bit expect_det(bit b);
        int ones_seen;
        ones_seen = (cur_ones > 0) ? cur_ones : last_ones;
        return !b && (ones_seen >= 2) && (cur_zeros + 1 >= 3);
    endfunction

    task automatic model_update(bit b);
        if (b) begin
            if (cur_ones < 1000) cur_ones++;
            cur_zeros = 0;
        end else begin
            if (cur_ones > 0) last_ones = cur_ones;
            cur_ones = 0;
            if (cur_zeros < 1000) cur_zeros++;
        end
    endtask

    task automatic check(bit exp, string tag);
        n_cmp++;
        if (det !== exp) begin
            n_bad++;
            $display("FAIL %s: det=%0b expected %0b", tag, det, exp);
        end
    endtask

    task automatic step(bit b, string tag);
        bit exp;
        @(negedge clk);
        din = b;
        #5;
        exp = expect_det(b);
        check(exp, tag);
        @(posedge clk);
        model_update(b);
    endtask

    task automatic play(string s, string tag);
        for (int i = 0; i < s.len(); i++) begin
            step(s[i] == 8'h31, tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: det=%0b expected run to complete", det);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset holds det low regardless of din
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            din = i[0];
            #5;
            check(1'b0, "R1 reset");
        end
        @(negedge clk);
        rst = 1'b0;
        cur_ones = 0; cur_zeros = 0; last_ones = 0;
        play("00000", "R1 zeros after reset");
        play("1000000", "R3 lone one");
        play("1100000", "R2 R5 basic");
        play("1", "R6 drop on one");
        play("1000", "R7 lone one after det");
        play("11110000", "R4 long ones");
        play("1100", "R7 re-arm after det");
        play("1000", "R8 restart");
        play("1101000", "R8 broken zeros");
        play("11001000", "R8 two zeros then one");
        play("110001100011", "R2 R6 R7 back to back");
        // random runs
        for (int r = 0; r < 1500; r++) begin
            bit b;
            int len;
            b   = 1'($urandom_range(0, 1));
            len = int'($urandom_range(1, 6));
            for (int k = 0; k < len; k++) begin
                step(b, b ? "R4 R6 random" : "R2 R3 R5 R8 random");
            end
        end
        // mid-stream reset clears history (R1)
        play("11", "R1 before reset");
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        #5;
        check(1'b0, "R1 mid reset");
        @(negedge clk);
        rst = 1'b0;
        cur_ones = 0; cur_zeros = 0; last_ones = 0;
        play("0000", "R1 history cleared");
        finish_run();
    end

endmodule